// File: doc/BRIEF.md
# Registered 8b/10b Line-Code Decoder with Disparity Guard

This block turns one 10-bit line code word per clock into an 8-bit byte and a control-character flag. It also watches the DC balance of the received stream. The word splits into a 6-bit group, which carries the low five byte bits, and a 4-bit group, which carries the high three. Each group is looked up on its own. The combined candidate is then accepted only if re-encoding it reproduces the received word under the disparity the decoder expects.

A two-state tracker holds the expected running disparity. It leaves reset negative and follows the ones count of every accepted word. A word that is no encoding at all raises the code-error flag. A word that is a valid encoding only under the opposite disparity raises the disparity-error flag. In both cases the word is discarded. The byte and control outputs keep their last good values, and the expected disparity stays frozen until a word matching it arrives. The block has no resynchronisation path. A wrong word never moves the tracker. Serial-to-parallel conversion and word alignment are done upstream.

Top module: `line_code_dec`

## Requirements
- R1: After reset the byte output is 0x00, the control flag is 0, both error flags are 0, and the expected disparity is negative.
- R2: Code word layout: bits [5:0] are the 6-bit group with its first line bit a at bit 5 down to i at bit 0. Bits [9:6] are the 4-bit group with f at bit 9 down to j at bit 6. Byte bits [4:0] come from the 6-bit group and bits [7:5] from the 4-bit group. For example 10'b1010001111 decodes to 0xBC with the control flag set.
- R3: A word equal to the standard encoding of a data byte under the expected disparity yields that byte with the control flag 0. The outputs update at the clock edge that samples the word.
- R4: Exactly twelve control values decode with the control flag set: low field 28 with any high field, and low field 23, 27, 29 or 30 with high field 7. The flag is never set with any other byte.
- R5: After an accepted word with six ones the expected disparity becomes positive. After one with four ones it becomes negative. Five ones leave it unchanged.
- R6: A word that equals no valid encoding under either disparity sets the code-error flag; 10'b0000111111 is one such word.
- R7: A word that is a valid encoding only under the disparity opposite to the expected one sets the disparity-error flag and not the code-error flag.
- R8: While either error flag is set, the byte and control outputs keep their previous values and the expected disparity does not change.
- R9: The first word that matches the expected disparity after an error is decoded normally, and both error flags clear on that same edge.
- R10: The two error flags are never set together. Both are registered in the same cycle as the byte they accompany.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 10 | Received code word, one per cycle |
| byte_o | output | 8 | Last correctly decoded byte |
| ctrl_o | output | 1 | Last decoded byte was a control character |
| code_err_o | output | 1 | Previous word was not a valid code word |
| disp_err_o | output | 1 | Previous word carried the wrong disparity |

## Verification
The bench models the decoder as a lookup built from its own encoder and compares every cycle. It walks all 256 bytes and all control values through a disparity-tracked stream, then feeds every possible 10-bit word once. Each of the following corner cases makes a faulty design visibly diverge from the model. A design that resynchronised to a wrong-disparity word would accept the following correct words as disparity errors. One that let an error word update the byte would show a changed byte_o during the error. The K28 4-bit groups with alternate polarity would be misread as other high values, and the run-limited alternate .7 groups would be taken for plain data. Words like 0000111111, and otherwise-valid halves joined under clashing disparities, must land in code error and not in disparity error.

// File: rtl/lc_dec_pkg.sv
package lc_dec_pkg;

    localparam int LO_W   = 5;
    localparam int HI_W   = 3;
    localparam int SUB6_W = LO_W + 1;
    localparam int SUB4_W = HI_W + 1;
    localparam int BYTE_W = LO_W + HI_W;
    localparam int WORD_W = SUB6_W + SUB4_W;
    localparam int ONES_W = $clog2(WORD_W + 1);
    localparam int HALF6  = SUB6_W / 2;
    localparam int HALF10 = WORD_W / 2;

    typedef logic [LO_W-1:0]   lo_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [SUB6_W-1:0] sub6_t;
    typedef logic [SUB4_W-1:0] sub4_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_e;

    typedef struct packed {
        logic is_ctrl;
        hi_t  hi;
        lo_t  lo;
    } sym_t;

    typedef struct packed {
        logic good;
        logic disp_bad;
        logic code_bad;
    } verdict_t;

    localparam lo_t   K_LO_28     = lo_t'(28);
    localparam hi_t   HI_SEVEN    = hi_t'(7);
    localparam sub6_t K28_SIX_NEG = 6'b001111;

    // 6-bit group for the negative-disparity side, first line bit in the MSB
    function automatic sub6_t six_neg(input lo_t v);
        sub6_t s;
        case (v)
            5'd0:  s = 6'b100111;  5'd1:  s = 6'b011101;
            5'd2:  s = 6'b101101;  5'd3:  s = 6'b110001;
            5'd4:  s = 6'b110101;  5'd5:  s = 6'b101001;
            5'd6:  s = 6'b011001;  5'd7:  s = 6'b111000;
            5'd8:  s = 6'b111001;  5'd9:  s = 6'b100101;
            5'd10: s = 6'b010101;  5'd11: s = 6'b110100;
            5'd12: s = 6'b001101;  5'd13: s = 6'b101100;
            5'd14: s = 6'b011100;  5'd15: s = 6'b010111;
            5'd16: s = 6'b011011;  5'd17: s = 6'b100011;
            5'd18: s = 6'b010011;  5'd19: s = 6'b110010;
            5'd20: s = 6'b001011;  5'd21: s = 6'b101010;
            5'd22: s = 6'b011010;  5'd23: s = 6'b111010;
            5'd24: s = 6'b110011;  5'd25: s = 6'b100110;
            5'd26: s = 6'b010110;  5'd27: s = 6'b110110;
            5'd28: s = 6'b001110;  5'd29: s = 6'b101110;
            5'd30: s = 6'b011110;  default: s = 6'b101011;
        endcase
        return s;
    endfunction

    function automatic sub6_t enc6(input lo_t v, input logic k28, input logic pos);
        sub6_t b;
        b = k28 ? K28_SIX_NEG : six_neg(v);
        if (!k28 && v == lo_t'(7)) begin
            return pos ? 6'b000111 : 6'b111000;
        end
        if (pos && $countones(b) != HALF6) begin
            return ~b;
        end
        return b;
    endfunction

    function automatic sub4_t enc4(input hi_t y, input logic pos, input logic alt,
                                   input logic k28);
        sub4_t c;
        case (y)
            3'd0:    c = pos ? 4'b0100 : 4'b1011;
            3'd1:    c = 4'b1001;
            3'd2:    c = 4'b0101;
            3'd3:    c = pos ? 4'b0011 : 4'b1100;
            3'd4:    c = pos ? 4'b0010 : 4'b1101;
            3'd5:    c = 4'b1010;
            3'd6:    c = 4'b0110;
            default: c = alt ? (pos ? 4'b1000 : 4'b0111) : (pos ? 4'b0001 : 4'b1110);
        endcase
        if (k28 && !pos && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6)) begin
            c = ~c;
        end
        return c;
    endfunction

    function automatic logic mid_pos(input sub6_t s, input logic pos);
        int n;
        n = $countones(s);
        if (n > HALF6) return 1'b1;
        if (n < HALF6) return 1'b0;
        return pos;
    endfunction

    function automatic logic is_ctrl_lo(input lo_t v);
        return (v == lo_t'(23)) || (v == lo_t'(27)) || (v == lo_t'(29)) || (v == lo_t'(30));
    endfunction

    function automatic logic alt_needed(input sym_t s, input logic mid);
        if (s.hi != HI_SEVEN) return 1'b0;
        if (s.is_ctrl) return 1'b1;
        if (mid) return (s.lo == lo_t'(11)) || (s.lo == lo_t'(13)) || (s.lo == lo_t'(14));
        return (s.lo == lo_t'(17)) || (s.lo == lo_t'(18)) || (s.lo == lo_t'(20));
    endfunction

    function automatic word_t encode(input sym_t s, input logic pos);
        logic  k28;
        logic  mid;
        sub6_t c6;
        sub4_t c4;
        k28 = s.is_ctrl && (s.lo == K_LO_28);
        c6  = enc6(s.lo, k28, pos);
        mid = mid_pos(c6, pos);
        c4  = enc4(s.hi, mid, alt_needed(s, mid), k28);
        return {c4, c6};
    endfunction

endpackage

// File: rtl/lc_sub6_dec.sv
module lc_sub6_dec
    import lc_dec_pkg::*;
(
    input  sub6_t grp_i,
    output lo_t   val_o,
    output logic  hit_o,
    output logic  k28_o,
    output logic  k28_mid_o
);

    always_comb begin
        val_o     = '0;
        hit_o     = 1'b0;
        k28_o     = 1'b0;
        k28_mid_o = 1'b0;
        if (grp_i == K28_SIX_NEG || grp_i == ~K28_SIX_NEG) begin
            val_o     = K_LO_28;
            hit_o     = 1'b1;
            k28_o     = 1'b1;
            k28_mid_o = (grp_i == K28_SIX_NEG);
        end else begin
            for (int v = 0; v < (1 << LO_W); v++) begin
                if (grp_i == enc6(lo_t'(v), 1'b0, 1'b0) ||
                    grp_i == enc6(lo_t'(v), 1'b0, 1'b1)) begin
                    val_o = lo_t'(v);
                    hit_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lc_sub4_dec.sv
module lc_sub4_dec
    import lc_dec_pkg::*;
(
    input  sub4_t grp_i,
    input  logic  k28_i,
    input  logic  k28_mid_i,
    output hi_t   val_o,
    output logic  hit_o,
    output logic  alt_o
);

    always_comb begin
        alt_o = (grp_i == 4'b0111) || (grp_i == 4'b1000);
        val_o = '0;
        hit_o = 1'b0;
        for (int y = 0; y < (1 << HI_W); y++) begin
            for (int r = 0; r < 2; r++) begin
                // a K28 group is only read at the disparity its 6-bit half implies
                if ((!k28_i || (r != 0) == k28_mid_i) &&
                    grp_i == enc4(hi_t'(y), r != 0, alt_o, k28_i)) begin
                    val_o = hi_t'(y);
                    hit_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lc_word_judge.sv
module lc_word_judge
    import lc_dec_pkg::*;
(
    input  word_t    code_i,
    input  sym_t     cand_i,
    input  logic     parts_ok_i,
    input  rd_e      exp_i,
    output verdict_t verdict_o
);

    word_t same_w;
    word_t other_w;

    always_comb begin
        same_w  = encode(cand_i, exp_i == RD_POS);
        other_w = encode(cand_i, exp_i != RD_POS);
        verdict_o.good     = parts_ok_i && (code_i == same_w);
        verdict_o.disp_bad = parts_ok_i && !verdict_o.good && (code_i == other_w);
        verdict_o.code_bad = !verdict_o.good && !verdict_o.disp_bad;
    end

endmodule

// File: rtl/lc_rd_track.sv
module lc_rd_track
    import lc_dec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  word_t code_i,
    output rd_e   rd_o
);

    logic [ONES_W-1:0] ones;
    rd_e               rd_nx;

    always_comb begin
        ones  = ONES_W'($countones(code_i));
        rd_nx = rd_o;
        if (load_i) begin
            if (ones > ONES_W'(HALF10)) rd_nx = RD_POS;
            else if (ones < ONES_W'(HALF10)) rd_nx = RD_NEG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_o <= RD_NEG;
        else     rd_o <= rd_nx;
    end

endmodule

// File: rtl/line_code_dec.sv
module line_code_dec
    import lc_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] code_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ctrl_o,
    output logic              code_err_o,
    output logic              disp_err_o
);

    lo_t      lo_val;
    logic     lo_hit;
    logic     k28;
    logic     k28_mid;
    hi_t      hi_val;
    logic     hi_hit;
    logic     hi_alt;
    sym_t     cand;
    verdict_t verdict;
    rd_e      exp_rd;

    lc_sub6_dec u_six (
        .grp_i     (code_i[SUB6_W-1:0]),
        .val_o     (lo_val),
        .hit_o     (lo_hit),
        .k28_o     (k28),
        .k28_mid_o (k28_mid)
    );

    lc_sub4_dec u_four (
        .grp_i     (code_i[WORD_W-1:SUB6_W]),
        .k28_i     (k28),
        .k28_mid_i (k28_mid),
        .val_o     (hi_val),
        .hit_o     (hi_hit),
        .alt_o     (hi_alt)
    );

    always_comb begin
        cand.lo      = lo_val;
        cand.hi      = hi_val;
        cand.is_ctrl = k28 || (hi_val == HI_SEVEN && hi_alt && is_ctrl_lo(lo_val));
    end

    lc_word_judge u_judge (
        .code_i     (code_i),
        .cand_i     (cand),
        .parts_ok_i (lo_hit && hi_hit),
        .exp_i      (exp_rd),
        .verdict_o  (verdict)
    );

    lc_rd_track u_rd (
        .clk    (clk),
        .rst    (rst),
        .load_i (verdict.good),
        .code_i (code_i),
        .rd_o   (exp_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o     <= '0;
            ctrl_o     <= 1'b0;
            code_err_o <= 1'b0;
            disp_err_o <= 1'b0;
        end else begin
            code_err_o <= verdict.code_bad;
            disp_err_o <= verdict.disp_bad;
            if (verdict.good) begin
                byte_o <= {cand.hi, cand.lo};
                ctrl_o <= cand.is_ctrl;
            end
        end
    end

endmodule

// File: rtl/line_code_dec_chk.sv
module line_code_dec_chk
    import lc_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] code_i,
    input logic [BYTE_W-1:0] byte_o,
    input logic              ctrl_o,
    input logic              code_err_o,
    input logic              disp_err_o,
    input rd_e               exp_rd
);

    logic [ONES_W-1:0] ones_now;
    logic              armed;

    assign ones_now = ONES_W'($countones(code_i));

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R10
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(code_err_o && disp_err_o));

    // R8
    p_hold_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (code_err_o || disp_err_o) |-> ($stable(byte_o) && $stable(ctrl_o)));

    // R8
    p_hold_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (code_err_o || disp_err_o) |-> $stable(exp_rd));

    // R4
    p_ctrl_values_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl_o |-> (byte_o[LO_W-1:0] == K_LO_28 ||
                    (byte_o[BYTE_W-1:LO_W] == HI_SEVEN && is_ctrl_lo(byte_o[LO_W-1:0]))));

    // R5
    p_rd_up_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !code_err_o && !disp_err_o && $past(ones_now) > ONES_W'(HALF10))
            |-> exp_rd == RD_POS);

    // R5
    p_rd_down_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !code_err_o && !disp_err_o && $past(ones_now) < ONES_W'(HALF10))
            |-> exp_rd == RD_NEG);

endmodule

bind line_code_dec line_code_dec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_i     (code_i),
    .byte_o     (byte_o),
    .ctrl_o     (ctrl_o),
    .code_err_o (code_err_o),
    .disp_err_o (disp_err_o),
    .exp_rd     (exp_rd)
);

// File: tb/line_code_dec_tb.sv
module line_code_dec_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] code_i = '0;
    logic [7:0] byte_o;
    logic       ctrl_o;
    logic       code_err_o;
    logic       disp_err_o;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string phase  = "R1";

    logic [1:0] okmask [1024];
    logic [8:0] decv   [1024];

    logic       m_rd;
    logic [7:0] m_byte;
    logic       m_k, m_ce, m_de;
    logic       tx_rd;

    line_code_dec u_dut (
        .clk        (clk),
        .rst        (rst),
        .code_i     (code_i),
        .byte_o     (byte_o),
        .ctrl_o     (ctrl_o),
        .code_err_o (code_err_o),
        .disp_err_o (disp_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference encoder: negative-side groups, the other side derived by polarity rules
    function automatic logic [5:0] t6(input logic [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
            3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
            6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
            9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
           15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
           18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
           21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
           27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
           30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [9:0] tx_enc(input logic [7:0] b, input logic k, input logic rd);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s6;
        logic [3:0] s4;
        logic       mid, alt, k28;
        x   = b[4:0];
        y   = b[7:5];
        k28 = k && x == 5'd28;
        s6  = k28 ? 6'b001111 : t6(x);
        if (rd && ($countones(s6) != 3 || (x == 5'd7 && !k28))) s6 = ~s6;
        if ($countones(s6) == 3) mid = rd;
        else                     mid = $countones(s6) > 3;
        alt = (y == 3'd7) && (k || (mid ? (x == 11 || x == 13 || x == 14)
                                        : (x == 17 || x == 18 || x == 20)));
        case (y)
            0: s4 = 4'b1011; 1: s4 = 4'b1001; 2: s4 = 4'b0101; 3: s4 = 4'b1100;
            4: s4 = 4'b1101; 5: s4 = 4'b1010; 6: s4 = 4'b0110;
            default: s4 = alt ? 4'b0111 : 4'b1110;
        endcase
        if (mid && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
        if (k28 && !mid && (y == 1 || y == 2 || y == 5 || y == 6)) s4 = ~s4;
        return {s4, s6};
    endfunction

    function automatic logic rd_after(input logic [9:0] w, input logic rd);
        if ($countones(w) > 5) return 1'b1;
        if ($countones(w) < 5) return 1'b0;
        return rd;
    endfunction

    task automatic model_step(input logic [9:0] w);
        if (okmask[w][m_rd]) begin
            m_byte = decv[w][7:0];
            m_k    = decv[w][8];
            m_ce   = 1'b0;
            m_de   = 1'b0;
            m_rd   = rd_after(w, m_rd);
        end else if (okmask[w] != 2'b00) begin
            m_ce = 1'b0;
            m_de = 1'b1;
        end else begin
            m_ce = 1'b1;
            m_de = 1'b0;
        end
    endtask

    // per-cycle comparison with the model; also covers R10 (flags never both set)
    task automatic compare();
        checks++;
        if (byte_o !== m_byte || ctrl_o !== m_k || code_err_o !== m_ce || disp_err_o !== m_de) begin
            errors++;
            $display("FAIL %s: got byte=%h k=%b ce=%b de=%b exp byte=%h k=%b ce=%b de=%b",
                     phase, byte_o, ctrl_o, code_err_o, disp_err_o, m_byte, m_k, m_ce, m_de);
        end
    endtask

    task automatic expect_out(input string req, input logic [7:0] b, input logic k,
                              input logic ce, input logic de);
        checks++;
        if (byte_o !== b || ctrl_o !== k || code_err_o !== ce || disp_err_o !== de) begin
            errors++;
            $display("FAIL %s: got byte=%h k=%b ce=%b de=%b exp byte=%h k=%b ce=%b de=%b",
                     req, byte_o, ctrl_o, code_err_o, disp_err_o, b, k, ce, de);
        end
    endtask

    task automatic drive(input logic [9:0] w);
        code_i = w;
        model_step(w);
    endtask

    task automatic apply(input logic [9:0] w);
        @(negedge clk);
        compare();
        drive(w);
    endtask

    task automatic send(input logic [7:0] b, input logic k);
        logic [9:0] w;
        w     = tx_enc(b, k, tx_rd);
        tx_rd = rd_after(w, tx_rd);
        apply(w);
    endtask

    function automatic logic [7:0] ctrl_byte(input int i);
        if (i < 8) return {3'(i), 5'd28};
        case (i)
            8:  return {3'd7, 5'd23};
            9:  return {3'd7, 5'd27};
            10: return {3'd7, 5'd29};
            default: return {3'd7, 5'd30};
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] w;
        for (int i = 0; i < 1024; i++) begin
            okmask[i] = 2'b00;
            decv[i]   = '0;
        end
        for (int r = 0; r < 2; r++) begin
            for (int b = 0; b < 256; b++) begin
                w = tx_enc(8'(b), 1'b0, r != 0);
                okmask[w][r] = 1'b1;
                decv[w] = {1'b0, 8'(b)};
            end
            for (int i = 0; i < 12; i++) begin
                w = tx_enc(ctrl_byte(i), 1'b1, r != 0);
                okmask[w][r] = 1'b1;
                decv[w] = {1'b1, ctrl_byte(i)};
            end
        end
        m_rd = 1'b0; m_byte = '0; m_k = 1'b0; m_ce = 1'b0; m_de = 1'b0;
        tx_rd = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R1", 8'h00, 1'b0, 1'b0, 1'b0);

        // R6: the named invalid word straight after reset
        phase = "R6";
        drive(10'b0000111111);
        // R2 R4: K28.5 with the negative-side layout decodes, so R1 left disparity negative
        phase = "R2";
        apply(10'b1010001111);
        expect_out("R6", 8'h00, 1'b0, 1'b1, 1'b0);
        // R5: six ones turned the expectation positive, so the positive form is now accepted
        phase = "R5";
        apply(10'b0101110000);
        expect_out("R2", 8'hBC, 1'b1, 1'b0, 1'b0);
        tx_rd = 1'b0;
        send(8'h00, 1'b0);
        expect_out("R5", 8'hBC, 1'b1, 1'b0, 1'b0);

        phase = "R3 R5";
        for (int b = 0; b < 256; b++) send(8'(b), 1'b0);

        phase = "R4";
        for (int i = 0; i < 12; i++) begin
            send(ctrl_byte(i), 1'b1);
            send(ctrl_byte(i), 1'b1);
        end

        phase = "R3";
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0) send(ctrl_byte($urandom_range(0, 11)), 1'b1);
            else        send(8'($urandom_range(0, 255)), 1'b0);
        end

        // R7 R8 R9: two wrong-disparity words, then recovery
        phase = "R7";
        send(8'h5A, 1'b0);
        apply(tx_enc(8'h00, 1'b0, ~tx_rd));
        apply(tx_enc(8'h03, 1'b0, ~tx_rd));
        expect_out("R7", 8'h5A, 1'b0, 1'b0, 1'b1);
        send(8'h77, 1'b0);
        expect_out("R8", 8'h5A, 1'b0, 1'b0, 1'b1);
        send(8'h11, 1'b0);
        expect_out("R9", 8'h77, 1'b0, 1'b0, 1'b0);

        // R8 R9: code error holds the byte, then a good word clears it
        phase = "R8";
        send(8'hC3, 1'b0);
        apply(10'b1111111111);
        send(8'h12, 1'b0);
        expect_out("R8", 8'hC3, 1'b0, 1'b1, 1'b0);
        send(8'h34, 1'b0);
        expect_out("R9", 8'h12, 1'b0, 1'b0, 1'b0);

        // every possible word, against the model
        phase = "R6 R7 R10";
        for (int i = 0; i < 1024; i++) apply(10'(i));
        @(negedge clk);
        compare();
        checks++;
        if (code_err_o && disp_err_o) begin
            errors++;
            $display("FAIL R10: got both flags, exp at most one");
        end

        tx_rd = m_rd;
        phase = "R9";
        for (int n = 0; n < 40; n++) send(8'($urandom_range(0, 255)), 1'b0);
        @(negedge clk);
        compare();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule